// File: doc/BRIEF.md
# Cache Line Refill Controller

This block fetches one 16-byte cache line from a behavioural main memory and hands it to a cache as four 32-bit words. The cache side raises `req_i` with a byte address while `req_ready_o` is high. The controller then spends one cycle sending the line address to memory. It waits out the fixed memory access latency and returns the words in ascending order, each marked by a one-cycle `word_valid_o`. `done_o` rises together with the last word.

A parameter selects the memory organisation. With one bank, every word needs its own full access and transfer, one after the other. With four word-interleaved banks, word k lives in bank k. All four accesses start together and only the transfers are serialised. This cuts a refill from 69 to 21 cycles at the default 16-cycle access latency. The memory contents are a fixed function of the word index, so a reader can tell the returned data apart.

Top module: `line_refill_ctrl`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `word_valid_o` and `done_o` are 0.
- R2: A request is taken at a rising clock edge where `req_i` and `req_ready_o` are both 1. `req_ready_o` is 0 from the next cycle until the cycle after `done_o`.
- R3: Each refill gives exactly four `word_valid_o` pulses. `word_idx_o` counts 0, 1, 2, 3 across them. Word k carries the value {w[15:0] ^ 16'hA5C3, ~w[15:0]}, where w = line*4 + k and line = address bits [9:4].
- R4: In single-bank mode (INTERLEAVED=0), cycle 1 is the cycle after the accepting edge. Word k is valid in cycle 18+17k, so the last word comes in cycle 69.
- R5: In interleaved mode (INTERLEAVED=1), word k is valid in cycle 18+k, so the last word comes in cycle 21.
- R6: `done_o` is 1 only in the cycle of word 3.
- R7: Address bits [3:0] and every bit above bit 9 have no effect on the returned line.
- R8: A request raised while `req_ready_o` is 0 is dropped. It changes neither the words returned nor their timing, and it adds no later refill.
- R9: A request raised in the cycle right after `done_o` is accepted. Its refill keeps the timing of R4 or R5, counted from its own accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Refill request |
| req_addr_i | input | ADDR_W | Byte address within the line to fetch |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| word_valid_o | output | 1 | Word data valid this cycle |
| word_idx_o | output | 2 | Index of the word within the line |
| word_data_o | output | 32 | Word data |
| done_o | output | 1 | Last word of the line this cycle |

## Verification
The cycle after the accepting edge is cycle 1. Word k is then due in cycle 18+17k for the single bank and in cycle 18+k for the interleaved banks. `done_o` is due with word 3, and `req_ready_o` returns one cycle later. The bench drives both variants with the same stimulus. At every falling edge it records the cycle number since acceptance and compares each word's cycle, index and data against these formulas. It also checks that requests made while busy, and a chained request made the cycle after `done_o`, land exactly where the formulas say.

// File: rtl/line_refill_pkg.sv
package line_refill_pkg;

  localparam int unsigned WORD_W        = 32;
  localparam int unsigned WORDS_PER_LN  = 4;
  localparam int unsigned WIDX_W        = $clog2(WORDS_PER_LN);
  localparam int unsigned LN_OFFS_W     = WIDX_W + 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT
  } refill_st_e;

  // fixed memory image: value depends only on the global word index
  function automatic logic [WORD_W-1:0] fill_word(input logic [15:0] w);
    return {w ^ 16'hA5C3, ~w};
  endfunction

endpackage

// File: rtl/refill_bank.sv
module refill_bank
  import line_refill_pkg::*;
#(
  parameter int unsigned DEPTH_AW   = 8,
  parameter int unsigned ACCESS_LAT = 16,
  parameter int unsigned BANK_ID    = 0,
  parameter int unsigned IDX_SHIFT  = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [DEPTH_AW-1:0] addr_i,
  input  logic                ack_i,
  output logic                rdy_o,
  output logic [WORD_W-1:0]   data_o
);

  localparam int unsigned DEPTH = 1 << DEPTH_AW;
  localparam int unsigned CNT_W = $clog2(ACCESS_LAT + 1);

  logic [WORD_W-1:0]   mem [DEPTH];
  logic                busy_q;
  logic                rdy_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [DEPTH_AW-1:0] addr_q;
  logic [WORD_W-1:0]   data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned j = 0; j < DEPTH; j++) begin
        mem[j] <= fill_word(16'((j << IDX_SHIFT) | BANK_ID));
      end
    end
  end

  // start has priority: it reloads the access even while data is being taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rdy_q  <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      rdy_q  <= 1'b0;
      cnt_q  <= '0;
      addr_q <= addr_i;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(ACCESS_LAT - 1)) begin
        busy_q <= 1'b0;
        rdy_q  <= 1'b1;
        data_q <= mem[addr_q];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (ack_i) begin
      rdy_q <= 1'b0;
    end
  end

  assign rdy_o  = rdy_q;
  assign data_o = data_q;

endmodule

// File: rtl/refill_seq.sv
module refill_seq
  import line_refill_pkg::*;
#(
  parameter int unsigned LINE_AW     = 6,
  parameter bit          INTERLEAVED = 1'b1,
  parameter int unsigned NUM_BANKS   = 4,
  parameter int unsigned BANK_AW     = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [LINE_AW-1:0]   line_i,
  output logic                 req_ready_o,
  output logic [NUM_BANKS-1:0] bank_start_o,
  output logic [BANK_AW-1:0]   bank_addr_o,
  input  logic [NUM_BANKS-1:0] bank_rdy_i,
  output logic [NUM_BANKS-1:0] bank_ack_o,
  output logic [WIDX_W-1:0]    word_idx_o,
  output logic                 word_valid_o,
  output logic                 done_o
);

  localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(WORDS_PER_LN - 1);

  refill_st_e         state_q;
  logic [LINE_AW-1:0] line_q;
  logic [WIDX_W-1:0]  idx_q;
  logic               cur_rdy;
  logic               word_vld;
  logic               last_word;

  assign word_vld  = (state_q == ST_WAIT) && cur_rdy;
  assign last_word = (idx_q == LAST_IDX);

  generate
    if (INTERLEAVED) begin : g_il
      assign cur_rdy     = bank_rdy_i[idx_q];
      assign bank_addr_o = line_q;
      for (genvar g = 0; g < NUM_BANKS; g++) begin : g_ctl
        assign bank_start_o[g] = (state_q == ST_ADDR);
        assign bank_ack_o[g]   = word_vld && (idx_q == WIDX_W'(g));
      end
    end else begin : g_sb
      logic [WIDX_W-1:0] nxt_idx;
      // next access is issued in the transfer cycle of the current word
      assign nxt_idx         = (state_q == ST_ADDR) ? '0 : idx_q + 1'b1;
      assign cur_rdy         = bank_rdy_i[0];
      assign bank_addr_o     = {line_q, nxt_idx};
      assign bank_start_o[0] = (state_q == ST_ADDR) || (word_vld && !last_word);
      assign bank_ack_o[0]   = word_vld;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            state_q <= ST_ADDR;
            line_q  <= line_i;
            idx_q   <= '0;
          end
        end
        ST_ADDR: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (word_vld) begin
            if (last_word) state_q <= ST_IDLE;
            else           idx_q   <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign word_idx_o   = idx_q;
  assign word_valid_o = word_vld;
  assign done_o       = word_vld && last_word;

endmodule

// File: rtl/line_refill_ctrl.sv
module line_refill_ctrl
  import line_refill_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LINE_AW     = 6,
  parameter int unsigned ACCESS_LAT  = 16,
  parameter bit          INTERLEAVED = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              word_valid_o,
  output logic [1:0]        word_idx_o,
  output logic [31:0]       word_data_o,
  output logic              done_o
);

  localparam int unsigned NUM_BANKS = INTERLEAVED ? WORDS_PER_LN : 1;
  localparam int unsigned BANK_AW   = INTERLEAVED ? LINE_AW : LINE_AW + WIDX_W;
  localparam int unsigned IDX_SHIFT = INTERLEAVED ? WIDX_W : 0;

  logic [LINE_AW-1:0]   line;
  logic [NUM_BANKS-1:0] bank_start;
  logic [NUM_BANKS-1:0] bank_ack;
  logic [NUM_BANKS-1:0] bank_rdy;
  logic [BANK_AW-1:0]   bank_addr;
  logic [WORD_W-1:0]    bank_data [NUM_BANKS];
  logic [WIDX_W-1:0]    widx;
  logic                 wvld;
  logic                 unused_addr;

  assign line        = req_addr_i[LN_OFFS_W +: LINE_AW];
  assign unused_addr = ^{req_addr_i[ADDR_W-1:LN_OFFS_W+LINE_AW], req_addr_i[LN_OFFS_W-1:0]};

  refill_seq #(
    .LINE_AW     (LINE_AW),
    .INTERLEAVED (INTERLEAVED),
    .NUM_BANKS   (NUM_BANKS),
    .BANK_AW     (BANK_AW)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .line_i       (line),
    .req_ready_o  (req_ready_o),
    .bank_start_o (bank_start),
    .bank_addr_o  (bank_addr),
    .bank_rdy_i   (bank_rdy),
    .bank_ack_o   (bank_ack),
    .word_idx_o   (widx),
    .word_valid_o (wvld),
    .done_o       (done_o)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    refill_bank #(
      .DEPTH_AW   (BANK_AW),
      .ACCESS_LAT (ACCESS_LAT),
      .BANK_ID    (g),
      .IDX_SHIFT  (IDX_SHIFT)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (bank_start[g]),
      .addr_i  (bank_addr),
      .ack_i   (bank_ack[g]),
      .rdy_o   (bank_rdy[g]),
      .data_o  (bank_data[g])
    );
  end

  generate
    if (INTERLEAVED) begin : g_mux_il
      assign word_data_o = wvld ? bank_data[widx] : '0;
    end else begin : g_mux_sb
      assign word_data_o = wvld ? bank_data[0] : '0;
    end
  endgenerate

  assign word_valid_o = wvld;
  assign word_idx_o   = widx;

endmodule

// File: rtl/line_refill_ctrl_chk.sv
module line_refill_ctrl_chk #(
  parameter int unsigned ACCESS_LAT  = 16,
  parameter bit          INTERLEAVED = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       req_ready_o,
  input logic       word_valid_o,
  input logic [1:0] word_idx_o,
  input logic       done_o
);

  logic [15:0] cyc_q;
  logic [2:0]  wcnt_q;
  logic [15:0] exp_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      wcnt_q <= '0;
    end else if (req_i && req_ready_o) begin
      cyc_q  <= 16'd1;
      wcnt_q <= '0;
    end else begin
      if (!req_ready_o) cyc_q <= cyc_q + 16'd1;
      if (word_valid_o) wcnt_q <= wcnt_q + 3'd1;
    end
  end

  assign exp_cyc = INTERLEAVED ? 16'(ACCESS_LAT + 2) + 16'(word_idx_o)
                               : 16'(ACCESS_LAT + 2) + 16'(ACCESS_LAT + 1) * 16'(word_idx_o);

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && req_ready_o |=> !req_ready_o);

  // R3
  word_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> {1'b0, word_idx_o} == wcnt_q);

  // R4
  word_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> cyc_q == exp_cyc);

  // R6
  done_with_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> word_valid_o && word_idx_o == 2'd3);

  // R8
  busy_words_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> !req_ready_o);

  // R9
  ready_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> req_ready_o);

endmodule

bind line_refill_ctrl line_refill_ctrl_chk #(
  .ACCESS_LAT  (ACCESS_LAT),
  .INTERLEAVED (INTERLEAVED)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .req_ready_o  (req_ready_o),
  .word_valid_o (word_valid_o),
  .word_idx_o   (word_idx_o),
  .done_o       (done_o)
);

// File: tb/line_refill_ctrl_tb.sv
module line_refill_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] addr = '0;

  logic        rdy_i, wv_i, done_i;
  logic [1:0]  idx_i;
  logic [31:0] data_i;
  logic        rdy_s, wv_s, done_s;
  logic [1:0]  idx_s;
  logic [31:0] data_s;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_total = 0;

  always #4 clk = ~clk;

  line_refill_ctrl #(.INTERLEAVED(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_addr_i(addr),
    .req_ready_o(rdy_i), .word_valid_o(wv_i), .word_idx_o(idx_i),
    .word_data_o(data_i), .done_o(done_i));

  line_refill_ctrl #(.INTERLEAVED(1'b0)) u_dut_single (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_addr_i(addr),
    .req_ready_o(rdy_s), .word_valid_o(wv_s), .word_idx_o(idx_s),
    .word_data_o(data_s), .done_o(done_s));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [31:0] a, input int k);
    logic [15:0] w;
    w = 16'(a[9:4]) * 16'd4 + 16'(k);
    return {w ^ 16'hA5C3, ~w};
  endfunction

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc_total);
      $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
      $finish;
    end
  end

  task automatic test_reset();
    @(negedge clk);
    chk(rdy_i == 1'b1, "R1 ready il", rdy_i, 1);
    chk(rdy_s == 1'b1, "R1 ready sb", rdy_s, 1);
    chk(wv_i == 1'b0 && wv_s == 1'b0, "R1 valid", {wv_i, wv_s}, 0);
    chk(done_i == 1'b0 && done_s == 1'b0, "R1 done", {done_i, done_s}, 0);
  endtask

  // poke: raise a second request in cycles 5..10 (both busy, R8)
  // chain: raise a second request in cycle 22 (interleaved idle, R9)
  task automatic run_refill(input logic [31:0] a, input bit poke, input bit chain,
                            input logic [31:0] a2);
    int ni = 0;
    int ns = 0;
    req  = 1'b1;
    addr = a;
    @(negedge clk);
    for (int n = 1; n <= 75; n++) begin
      if (n == 1) begin
        chk(rdy_i == 1'b0, "R2 busy il", rdy_i, 0);
        chk(rdy_s == 1'b0, "R2 busy sb", rdy_s, 0);
      end
      if (n == 22) chk(rdy_i == 1'b1, "R9 ready after done", rdy_i, 1);
      if (wv_i) begin
        int k = ni % 4;
        int base = (ni < 4) ? 0 : 22;
        logic [31:0] la = (ni < 4) ? a : a2;
        chk(n == base + 18 + k, "R5 il word time", n, base + 18 + k);
        chk(idx_i == 2'(k), "R3 il index", idx_i, k);
        chk(data_i == exp_word(la, k), "R3 R7 il data", data_i, exp_word(la, k));
        chk(done_i == (k == 3), "R6 il done", done_i, k == 3);
        ni++;
      end else begin
        chk(done_i == 1'b0, "R6 il done idle", done_i, 0);
      end
      if (wv_s) begin
        chk(n == 18 + 17 * ns, "R4 sb word time", n, 18 + 17 * ns);
        chk(idx_s == 2'(ns), "R3 sb index", idx_s, ns);
        chk(data_s == exp_word(a, ns), "R3 R7 sb data", data_s, exp_word(a, ns));
        chk(done_s == (ns == 3), "R6 sb done", done_s, ns == 3);
        ns++;
      end
      if (poke && n >= 5 && n <= 10) begin
        req = 1'b1; addr = a2;
      end else if (chain && n == 22) begin
        req = 1'b1; addr = a2;
      end else begin
        req = 1'b0;
      end
      @(negedge clk);
    end
    chk(ni == (chain ? 8 : 4), "R3 R8 il word count", ni, chain ? 8 : 4);
    chk(ns == 4, "R3 R8 sb word count", ns, 4);
    chk(rdy_i && rdy_s, "R2 ready at end", {rdy_i, rdy_s}, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    // R3 R4 R5: plain refill of line 4
    run_refill(32'h0000_0040, 1'b0, 1'b0, 32'h0);
    // R7: low offset bits and high bits set, line 0x3A
    run_refill(32'hFFFF_F3AF, 1'b0, 1'b0, 32'h0);
    // R8: requests while busy are dropped
    run_refill(32'h0000_0150, 1'b1, 1'b0, 32'h0000_0260);
    // R9: chained request the cycle after done
    run_refill(32'h0000_07F0, 1'b0, 1'b1, 32'h0000_0010);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule